// File: doc/BRIEF.md
# Wide-Line Flash Read Prefetch Buffer

This block sits between a 64-bit bus-side read port and a slow array port that returns a whole 256-bit line, made of four double-words, each with its own 8-bit check code. It keeps the most recently fetched line as the current line. It also keeps a second buffer for the next sequential line, which it fetches in the background while the current line is being read out. A bus read names a double-word address and a beat count. The block sends the beats from the buffered line, one double-word per cycle, and corrects single-bit errors in each double-word on the way out.

A read that finds its line already buffered is served without touching the array and is flagged as a hit. Any other read drops a pending background fetch and starts a demand fetch. Software can switch prefetching off, and an invalidate input empties both buffers after the array contents have changed.

Top module: `flash_line_prefetch`

## Requirements
- R1: After reset, `rd_valid` and `arr_req` are low and both line buffers are empty, so the first read is a miss (`rd_hit`=0).
- R2: A read is granted (`rd_gnt`=1) exactly when `rd_req` is high while no read is in progress. On a hit, the first beat appears in the cycle after the grant with `rd_hit`=1. On a miss, `rd_hit` is 0 on every beat.
- R3: `rd_len` encodes the beat count minus one. Beats come out on consecutive cycles, starting at `rd_addr` and in ascending double-word order. `rd_last` marks the final beat, and at least one idle cycle follows it.
- R4: A burst never crosses a line boundary. The lower two bits of `rd_addr` give the double-word within the line, and the beat count is cut down to the number of double-words left up to the end of that line.
- R5: A read whose line tag (`rd_addr` without its lower two bits) matches the valid current line makes no array request.
- R6: With `pf_en`=1, once a line starts being delivered and no next line is buffered, the block requests line tag+1 from the array. A later read to that line is a hit and makes no demand request.
- R7: With `pf_en`=0, no background request is issued, and a line prefetched earlier is not used: a read to it is a miss.
- R8: A miss aborts an outstanding background fetch and discards its data. The demand request is issued only after that fetch has returned, and a later read to the aborted line is a miss.
- R9: `inval` empties both buffers and discards any fetch in flight. A read granted in the same cycle as `inval`, or afterwards, is a miss.
- R10: At most one array fetch is outstanding. `arr_req` is a one-cycle pulse, is never high on two consecutive cycles, and is not raised again until `arr_valid` has returned the previous line.
- R11: Check byte c of a double-word d is defined as follows. For k in 0..6, c[k] is the XOR of every d[i] where bit k of i+1 is set, and c[7] is the XOR of all of d. If the stored byte and the recomputed byte differ with c[7] differing and a position value p in 1..64 in bits 6:0, bit p-1 is inverted on output. Any difference raises `rd_ecc_err` on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_en | input | 1 | Enables background fetch and the use of prefetched lines |
| inval | input | 1 | Empties both line buffers |
| rd_req | input | 1 | Bus read request |
| rd_addr | input | AW | Double-word address of the first beat |
| rd_len | input | 2 | Requested beats minus one |
| rd_gnt | output | 1 | Read accepted this cycle |
| rd_valid | output | 1 | Beat data valid |
| rd_data | output | 64 | Corrected double-word |
| rd_hit | output | 1 | Current burst was served from a buffered line |
| rd_last | output | 1 | Final beat of the burst |
| rd_ecc_err | output | 1 | Check mismatch seen on this beat |
| arr_req | output | 1 | One-cycle array fetch request |
| arr_line | output | AW-2 | Line tag being fetched |
| arr_valid | input | 1 | Array line returned |
| arr_data | input | 256 | Returned line, double-word k in bits 64k+63:64k |
| arr_ecc | input | 32 | Check bytes, byte k for double-word k |

## Verification
A hit delivers beat k exactly k+1 cycles after the granting edge. The scoreboard stamps each expected hit beat with that cycle number and compares it against a free-running cycle counter when the beat is popped. A miss becomes due a variable number of cycles after the array returns its line, so miss beats are checked for order, content and flags only. Array traffic has no fixed timing, so after each read the bench waits long enough for every background request to settle, then compares the number of array requests and the last tag requested against the totals implied by R5 to R8.

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch #(
  parameter int AW = 16,
  parameter int NW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pf_en,
  input  logic                      inval,
  input  logic                      rd_req,
  input  logic [AW-1:0]             rd_addr,
  input  logic [$clog2(NW)-1:0]     rd_len,
  output logic                      rd_gnt,
  output logic                      rd_valid,
  output logic [63:0]               rd_data,
  output logic                      rd_hit,
  output logic                      rd_last,
  output logic                      rd_ecc_err,
  output logic                      arr_req,
  output logic [AW-$clog2(NW)-1:0]  arr_line,
  input  logic                      arr_valid,
  input  logic [NW*64-1:0]          arr_data,
  input  logic [NW*8-1:0]           arr_ecc
);
  localparam int OW = $clog2(NW);
  localparam int TW = AW - OW;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_BURST} st_t;

  function automatic logic [7:0] ecc_of(input logic [63:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 7; k++)
        if ((((i + 1) >> k) & 1) == 1) c[k] = c[k] ^ d[i];
      c[7] = c[7] ^ d[i];
    end
    return c;
  endfunction

  function automatic logic [64:0] ecc_fix(input logic [63:0] d, input logic [7:0] e);
    logic [7:0]  s;
    logic [63:0] o;
    s = ecc_of(d) ^ e;
    o = d;
    if (s[7])
      for (int i = 0; i < 64; i++)
        if (s[6:0] == 7'(i + 1)) o[i] = ~o[i];
    return {|s, o};
  endfunction

  st_t                    st;
  logic                   cur_v, pf_v, busy, fkind, fdrop, need, hit_r;
  logic [TW-1:0]          cur_tag, pf_tag, ftag, req_tag;
  logic [NW-1:0][63:0]    cur_d, pf_d;
  logic [NW-1:0][7:0]     cur_e, pf_e;
  logic [OW-1:0]          ofs, left;

  logic [TW-1:0] rtag;
  logic [OW-1:0] rofs, lim, nleft;
  logic          hit_cur, hit_pf, issue_dem, issue_pf;
  logic [64:0]   fixed;

  assign rtag    = rd_addr[AW-1:OW];
  assign rofs    = rd_addr[OW-1:0];
  assign lim     = ~rofs;
  assign nleft   = (rd_len > lim) ? lim : rd_len;
  assign hit_cur = !inval && cur_v && cur_tag == rtag;
  assign hit_pf  = !inval && pf_en && pf_v && pf_tag == rtag;

  assign rd_gnt    = rd_req && st == S_IDLE;
  assign issue_dem = st == S_FETCH && need && !busy;
  assign issue_pf  = st == S_BURST && pf_en && cur_v && !pf_v && !busy && !inval;
  assign arr_req   = issue_dem || issue_pf;
  assign arr_line  = issue_pf ? cur_tag + 1'b1 : req_tag;

  assign fixed      = ecc_fix(cur_d[ofs], cur_e[ofs]);
  assign rd_valid   = st == S_BURST;
  assign rd_data    = fixed[63:0];
  assign rd_ecc_err = rd_valid && fixed[64];
  assign rd_last    = rd_valid && left == '0;
  assign rd_hit     = rd_valid && hit_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur_v <= 1'b0; pf_v <= 1'b0; busy <= 1'b0; fkind <= 1'b0;
      fdrop <= 1'b0; need <= 1'b0; hit_r <= 1'b0;
      cur_tag <= '0; pf_tag <= '0; ftag <= '0; req_tag <= '0;
      cur_d <= '0; pf_d <= '0; cur_e <= '0; pf_e <= '0;
      ofs <= '0; left <= '0;
    end else begin
      if (arr_valid && busy) begin
        busy <= 1'b0;
        if (!fdrop) begin
          if (fkind) begin
            pf_v <= 1'b1; pf_tag <= ftag; pf_d <= arr_data; pf_e <= arr_ecc;
          end else begin
            cur_v <= 1'b1; cur_tag <= ftag; cur_d <= arr_data; cur_e <= arr_ecc;
            st <= S_BURST;
          end
        end
      end
      if (arr_req) begin
        busy  <= 1'b1;
        fkind <= issue_pf;
        ftag  <= arr_line;
        fdrop <= 1'b0;
        if (issue_dem) need <= 1'b0;
      end
      case (st)
        S_IDLE: if (rd_gnt) begin
          ofs <= rofs; left <= nleft; req_tag <= rtag;
          if (hit_cur) begin
            st <= S_BURST; hit_r <= 1'b1;
          end else if (hit_pf) begin
            cur_v <= 1'b1; cur_tag <= pf_tag; cur_d <= pf_d; cur_e <= pf_e;
            pf_v <= 1'b0; st <= S_BURST; hit_r <= 1'b1;
          end else begin
            st <= S_FETCH; need <= 1'b1; hit_r <= 1'b0; pf_v <= 1'b0;
            if (busy) fdrop <= 1'b1;
          end
        end
        S_BURST: begin
          ofs  <= ofs + 1'b1;
          left <= left - 1'b1;
          if (left == '0) st <= S_IDLE;
        end
        default: ;
      endcase
      if (inval) begin
        cur_v <= 1'b0;
        pf_v  <= 1'b0;
        if (busy || arr_req) fdrop <= 1'b1;
        if (st == S_FETCH) begin
          need <= 1'b1;
          st   <= S_FETCH;
        end
      end
    end
  end

  assert_hit_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt |=> (rd_valid == rd_hit));
  assert_burst_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> rd_valid);
  assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last) |=> !rd_valid);
  assert_pulse_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> !arr_req);
  assert_no_pf_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !pf_en) |-> !rd_valid);
  assert_inval_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_gnt && $past(inval)) |=> !rd_hit);
endmodule

// File: tb/flash_line_prefetch_bench.sv
module flash_line_prefetch_bench;
  logic clk = 1'b0, rst_n = 1'b0, pf_en = 1'b0, inval = 1'b0, rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  rd_len = '0;
  logic rd_gnt, rd_valid, rd_hit, rd_last, rd_ecc_err, arr_req;
  logic [63:0] rd_data;
  logic [13:0] arr_line;
  logic arr_valid = 1'b0;
  logic [255:0] arr_data = '0;
  logic [31:0]  arr_ecc = '0;

  flash_line_prefetch u_flash_line_prefetch (.*);

  always #10 clk = ~clk;

  typedef struct { logic [63:0] d; bit last; bit hit; bit err; int due; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0, cyc = 0, nreq = 0, last_line = -1, lat = 3;
  int err_line = -1, err_word = 0, err_bit = 0;
  bit done = 0, pend = 0;
  int pline = 0, cnt = 0;

  function automatic logic [63:0] dw(int a);
    return {32'(a) * 32'h9E3779B1, 32'h5A5A0000 ^ 32'(a)};
  endfunction

  function automatic logic [7:0] code(logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 7; k++) if ((((i + 1) >> k) & 1) == 1) c[k] ^= d[i];
      c[7] ^= d[i];
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    arr_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        for (int k = 0; k < 4; k++) begin
          logic [63:0] w;
          w = dw(pline * 4 + k);
          arr_ecc[k*8 +: 8] = code(w);
          if (pline == err_line && k == err_word) w[err_bit] = ~w[err_bit];
          arr_data[k*64 +: 64] = w;
        end
        arr_valid = 1'b1;
        pend = 0;
      end else cnt--;
    end
    if (rst_n && arr_req) begin
      chk(!pend, "R10", "request while outstanding", 1, 0);
      pend = 1; pline = int'(arr_line); cnt = lat; nreq++; last_line = int'(arr_line);
    end
  end

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q.size() == 0) chk(0, "R3", "unexpected beat", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rd_data == e.d, "R3/R11", "data", rd_data, e.d);
        chk(rd_last == e.last, "R3/R4", "last", rd_last, e.last);
        chk(rd_hit == e.hit, "R2/R5/R6/R7/R8/R9", "hit", rd_hit, e.hit);
        chk(rd_ecc_err == e.err, "R11", "ecc flag", rd_ecc_err, e.err);
        if (e.due >= 0) chk(cyc == e.due, "R2", "beat cycle", cyc, e.due);
      end
    end
  end

  task automatic rd(int a, int len, bit hit);
    int ofs, beats, gc;
    ofs = a % 4;
    beats = (len + 1 > 4 - ofs) ? 4 - ofs : len + 1;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 16'(a); rd_len = 2'(len);
    #1;
    while (!rd_gnt) begin @(negedge clk); #1; end
    gc = cyc;
    for (int k = 0; k < beats; k++) begin
      exp_t e;
      e.d = dw(a + k); e.last = (k == beats - 1); e.hit = hit;
      e.err = ((a / 4) == err_line && ((a + k) % 4) == err_word);
      e.due = hit ? gc + 1 + k : -1;
      q.push_back(e);
    end
    @(negedge clk);
    rd_req = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
    chk(arr_req == 0, "R1", "arr_req after reset", arr_req, 0);
    pf_en = 1'b1;
    rd(0, 3, 0);                              // R1 empty buffers miss, R3 four beats
    settle(10);
    chk(nreq == 2, "R6", "requests after first read", nreq, 2);
    chk(last_line == 1, "R6", "prefetch tag", last_line, 1);
    rd(6, 3, 1);                              // R6 prefetch hit, R4 truncated to 2 beats
    settle(10);
    chk(nreq == 3, "R6", "no demand on prefetch hit", nreq, 3);
    chk(last_line == 2, "R6", "next prefetch tag", last_line, 2);
    rd(5, 0, 1);                              // R5 current line hit
    settle(5);
    chk(nreq == 3, "R5", "no array access on hit", nreq, 3);
    pf_en = 1'b0;
    rd(8, 1, 0);                              // R7 buffered prefetch ignored
    settle(10);
    chk(nreq == 4 && last_line == 2, "R7", "demand only, no prefetch", nreq, 4);
    rd(9, 0, 1);
    @(negedge clk); inval = 1'b1; @(negedge clk); inval = 1'b0;
    rd(9, 0, 0);                              // R9 miss after invalidate
    settle(5);
    chk(nreq == 5, "R9", "demand after invalidate", nreq, 5);
    err_line = 5; err_word = 1; err_bit = 17;
    pf_en = 1'b1;
    rd(20, 3, 0);                             // R11 corrected beat flagged
    settle(10);
    chk(nreq == 7, "R6", "prefetch after ECC read", nreq, 7);
    lat = 20;
    rd(32, 0, 0);
    settle(2);
    chk(nreq == 9 && last_line == 9, "R6", "prefetch in flight", nreq, 9);
    rd(80, 0, 0);                             // R8 abort pending prefetch
    settle(45);
    chk(nreq == 11, "R8", "demand then new prefetch", nreq, 11);
    rd(36, 0, 0);                             // R8 aborted line is a miss
    settle(45);
    chk(last_line == 10, "R6", "prefetch after line 9", last_line, 10);
    rd(40, 3, 1);                             // R6 hit, R3 full burst
    rd(43, 3, 1);                             // R4 single beat at line end
    settle(45);
    chk(q.size() == 0, "R3", "all beats seen", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule